// File: doc/BRIEF.md
# Fail-Safe Oversampled Two-Channel Output Controller

This block plays out oversampled digital output data on two channels. The controller supplies one data word per communication cycle. That word holds a block of samples for each channel, and the block emits one sample per sample-clock period. A sample counter marks the cycle boundaries. A new block is taken over only at a boundary, and only when an accepted data strobe without a continuity error came in during the cycle that is ending.

When data stops arriving, the block moves through three phases. Phase 1 is normal playout. Phase 2 is a missed cycle: a boundary was reached with no good data. Phase 3 is an expired watchdog: the watchdog counts sample periods since the last good cycle and expires when it reaches a programmable limit. Each channel has a configuration byte that chooses what the output does in phases 2 and 3. The choices are a fixed level, hold, replay of buffer contents, an alternating pattern, or driver off. Both bytes are written in a single 16-bit access.

Top module: `failsafe_out`

## Requirements
- R1: After reset, both channel levels are 0, both output-enables are 1, both configuration bytes are 0, the watchdog count is 0, and the block is in phase 1 with an all-zero sample block.
- R2: In phase 1, during sample period k (k = 0..NSAMP-1) of a cycle, channel c outputs bit c*NSAMP+k of the most recently loaded data word. A word is loaded at the boundary that closes a cycle in which the latest data strobe had its cycle-error flag low.
- R3: A boundary with no strobe in the cycle, or whose latest strobe carried the cycle-error flag, enters phase 2. With enable bit 0 of the channel byte clear, that channel replays its last loaded block.
- R4: In phase 2 with enable set, bits 3:1 of the channel byte select the output: 000 gives 0, 001 gives 1, 010 gives the final sample (index NSAMP-1) of the last loaded block, 011 gives the samples of the most recently strobed word even if it was flagged, 100 alternates, 101 turns the driver off, and 110/111 give 0.
- R5: The watchdog counts sample periods since the last load. It saturates at the programmed limit. While the count equals the limit, phase 3 applies, and phase 3 overrides phase 2.
- R6: In phase 3, a channel with enable clear outputs 0. With enable set, bits 6:4 select: 000 gives 0, 001 gives 1, 010 gives the final sample of the last loaded block, 011 replays the last loaded block, 100 alternates, 101 turns the driver off, and 110/111 give 0.
- R7: The alternating pattern outputs 0 in the first sample period after a phase change and inverts on every later sample period while the phase is unchanged.
- R8: Driver-off sets the output-enable to 0 and forces the level to 0.
- R9: A configuration write stores the low byte for channel 0 and the high byte for channel 1 on the same clock edge, and takes effect from the next sample period.
- R10: A load returns the block to phase 1 from phase 2 or phase 3 at that boundary and restarts the watchdog at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample period per cycle |
| rst | input | 1 | Synchronous active-high reset |
| data_word | input | NCH*NSAMP | Per-cycle sample word, channel c in bits c*NSAMP upward, sample 0 lowest |
| data_valid | input | 1 | Strobe: data_word is valid this clock |
| cycle_err | input | 1 | Continuity error flag accompanying data_valid |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | NCH*8 | Configuration bytes, channel 0 in the low byte |
| wd_limit | input | WD_W | Watchdog timeout in sample periods (at least 1) |
| out_lvl | output | NCH | Channel output levels |
| out_oe | output | NCH | Channel output-enables |

## Verification
The bench runs steady good cycles with random sample words to confirm in-order playout. It then runs cycles with no strobe and cycles whose strobe is flagged. These separate the hold, stale-buffer and replay sources, because a flagged word reaches the buffer but is never loaded. Silent runs longer than the watchdog limit, mixed with random configuration bytes that include the unused codes, test that phase 3 overrides phase 2 and that the alternating pattern restarts at 0. Good cycles after each loss test the return to phase 1.

// File: rtl/fso_pkg.sv
package fso_pkg;

    localparam int CFG_W = 8;

    typedef enum logic [1:0] {
        PH_RUN  = 2'd0,
        PH_MISS = 2'd1,
        PH_WDOG = 2'd2
    } phase_e;

    typedef enum logic [2:0] {
        ACT_ZERO,
        ACT_ONE,
        ACT_HOLD,
        ACT_BUF,
        ACT_BLK,
        ACT_ALT,
        ACT_OFF
    } act_e;

    typedef struct packed {
        logic       rsvd;
        logic [2:0] wd_code;
        logic [2:0] miss_code;
        logic       en;
    } chan_cfg_t;

    function automatic act_e code_to_act(input logic [2:0] code, input act_e rep);
        case (code)
            3'd0:    code_to_act = ACT_ZERO;
            3'd1:    code_to_act = ACT_ONE;
            3'd2:    code_to_act = ACT_HOLD;
            3'd3:    code_to_act = rep;
            3'd4:    code_to_act = ACT_ALT;
            3'd5:    code_to_act = ACT_OFF;
            default: code_to_act = ACT_ZERO;
        endcase
    endfunction

    function automatic act_e pick_act(input phase_e ph, input chan_cfg_t cfg);
        case (ph)
            PH_MISS: pick_act = cfg.en ? code_to_act(cfg.miss_code, ACT_BUF) : ACT_BLK;
            PH_WDOG: pick_act = cfg.en ? code_to_act(cfg.wd_code, ACT_BLK) : ACT_ZERO;
            default: pick_act = ACT_BLK;
        endcase
    endfunction

endpackage

// File: rtl/fso_cycle_seq.sv
module fso_cycle_seq
    import fso_pkg::*;
#(
    parameter int NSAMP = 10,
    parameter int WD_W  = 20,
    localparam int IW   = (NSAMP > 1) ? $clog2(NSAMP) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            data_valid,
    input  logic            cycle_err,
    input  logic [WD_W-1:0] wd_limit,
    output logic [IW-1:0]   idx,
    output logic            load,
    output phase_e          phase,
    output logic            alt,
    output logic [WD_W-1:0] wd_cnt
);

    localparam logic [IW-1:0] LAST_IDX = IW'(NSAMP - 1);

    logic [IW-1:0]   idx_q, idx_n;
    logic            pend_v_q, pend_e_q;
    logic            miss_q, miss_n;
    logic [WD_W-1:0] wd_q, wd_n;
    logic            alt_q;
    logic            last, eff_v, eff_e;
    phase_e          ph_cur, ph_nxt;

    always_comb begin
        last   = (idx_q == LAST_IDX);
        eff_v  = pend_v_q | data_valid;
        eff_e  = data_valid ? cycle_err : pend_e_q;
        load   = last & eff_v & ~eff_e;
        idx_n  = last ? '0 : idx_q + 1'b1;
        miss_n = last ? ~load : miss_q;
        if (load)
            wd_n = '0;
        else if (wd_q >= wd_limit)
            wd_n = wd_q;
        else
            wd_n = wd_q + 1'b1;
        if (wd_q >= wd_limit)
            ph_cur = PH_WDOG;
        else if (miss_q)
            ph_cur = PH_MISS;
        else
            ph_cur = PH_RUN;
        if (wd_n >= wd_limit)
            ph_nxt = PH_WDOG;
        else if (miss_n)
            ph_nxt = PH_MISS;
        else
            ph_nxt = PH_RUN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q    <= '0;
            pend_v_q <= 1'b0;
            pend_e_q <= 1'b0;
            miss_q   <= 1'b0;
            wd_q     <= '0;
            alt_q    <= 1'b0;
        end else begin
            idx_q    <= idx_n;
            pend_v_q <= last ? 1'b0 : eff_v;
            pend_e_q <= last ? 1'b0 : eff_e;
            miss_q   <= miss_n;
            wd_q     <= wd_n;
            alt_q    <= (ph_nxt != ph_cur) ? 1'b0 : ~alt_q;
        end
    end

    assign idx    = idx_q;
    assign phase  = ph_cur;
    assign alt    = alt_q;
    assign wd_cnt = wd_q;

endmodule

// File: rtl/fso_chan.sv
module fso_chan
    import fso_pkg::*;
#(
    parameter int NSAMP = 10,
    localparam int IW   = (NSAMP > 1) ? $clog2(NSAMP) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSAMP-1:0] din,
    input  logic             data_valid,
    input  logic             load,
    input  logic [IW-1:0]    idx,
    input  logic             alt,
    input  act_e             act,
    output logic             lvl,
    output logic             oe
);

    logic [NSAMP-1:0] blk_q;
    logic [NSAMP-1:0] inb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_q <= '0;
            inb_q <= '0;
        end else begin
            if (data_valid)
                inb_q <= din;
            if (load)
                blk_q <= data_valid ? din : inb_q;
        end
    end

    always_comb begin
        oe = 1'b1;
        case (act)
            ACT_ONE:  lvl = 1'b1;
            ACT_HOLD: lvl = blk_q[NSAMP-1];
            ACT_BUF:  lvl = inb_q[idx];
            ACT_BLK:  lvl = blk_q[idx];
            ACT_ALT:  lvl = alt;
            ACT_OFF: begin
                lvl = 1'b0;
                oe  = 1'b0;
            end
            default:  lvl = 1'b0;
        endcase
    end

endmodule

// File: rtl/failsafe_out.sv
module failsafe_out
    import fso_pkg::*;
#(
    parameter int NSAMP = 10,
    parameter int NCH   = 2,
    parameter int WD_W  = 20,
    localparam int IW   = (NSAMP > 1) ? $clog2(NSAMP) : 1,
    localparam int DW   = NCH * NSAMP,
    localparam int CW   = NCH * CFG_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DW-1:0]   data_word,
    input  logic            data_valid,
    input  logic            cycle_err,
    input  logic            cfg_we,
    input  logic [CW-1:0]   cfg_wdata,
    input  logic [WD_W-1:0] wd_limit,
    output logic [NCH-1:0]  out_lvl,
    output logic [NCH-1:0]  out_oe
);

    logic [IW-1:0]   idx;
    logic            load;
    phase_e          phase;
    logic            alt;
    logic [WD_W-1:0] wd_cnt;
    chan_cfg_t       cfg_q [NCH];

    fso_cycle_seq #(.NSAMP(NSAMP), .WD_W(WD_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .data_valid (data_valid),
        .cycle_err  (cycle_err),
        .wd_limit   (wd_limit),
        .idx        (idx),
        .load       (load),
        .phase      (phase),
        .alt        (alt),
        .wd_cnt     (wd_cnt)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        act_e act;

        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[c] <= '0;
            else if (cfg_we)
                cfg_q[c] <= chan_cfg_t'(cfg_wdata[c*CFG_W +: CFG_W]);
        end

        assign act = pick_act(phase, cfg_q[c]);

        fso_chan #(.NSAMP(NSAMP)) u_chan (
            .clk        (clk),
            .rst        (rst),
            .din        (data_word[c*NSAMP +: NSAMP]),
            .data_valid (data_valid),
            .load       (load),
            .idx        (idx),
            .alt        (alt),
            .act        (act),
            .lvl        (out_lvl[c]),
            .oe         (out_oe[c])
        );
    end

endmodule

// File: rtl/fso_chk.sv
module fso_chk
    import fso_pkg::*;
#(
    parameter int NSAMP = 10,
    parameter int NCH   = 2,
    parameter int WD_W  = 20,
    localparam int IW   = (NSAMP > 1) ? $clog2(NSAMP) : 1
) (
    input logic            clk,
    input logic            rst,
    input logic [IW-1:0]   idx,
    input logic            load,
    input phase_e          phase,
    input logic            alt,
    input logic [WD_W-1:0] wd_cnt,
    input logic [WD_W-1:0] wd_limit,
    input logic [NCH-1:0]  out_lvl,
    input logic [NCH-1:0]  out_oe
);

    // R8
    off_low_chk: assert property (@(posedge clk) disable iff (rst)
        (out_lvl & ~out_oe) == '0);

    // R2
    idx_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        idx == IW'(NSAMP - 1) |=> idx == '0);

    // R10
    load_run_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (phase == PH_RUN) && (wd_cnt == '0));

    // R3
    miss_enter_chk: assert property (@(posedge clk) disable iff (rst)
        (idx == IW'(NSAMP - 1)) && !load |=> phase != PH_RUN);

    // R5
    wd_count_chk: assert property (@(posedge clk) disable iff (rst)
        !load && (wd_cnt < wd_limit) && $stable(wd_limit) |=> wd_cnt == $past(wd_cnt) + 1'b1);

    // R7
    alt_start_chk: assert property (@(posedge clk) disable iff (rst)
        phase != $past(phase) |-> !alt);

endmodule

bind failsafe_out fso_chk #(.NSAMP(NSAMP), .NCH(NCH), .WD_W(WD_W)) u_fso_chk (
    .clk      (clk),
    .rst      (rst),
    .idx      (idx),
    .load     (load),
    .phase    (phase),
    .alt      (alt),
    .wd_cnt   (wd_cnt),
    .wd_limit (wd_limit),
    .out_lvl  (out_lvl),
    .out_oe   (out_oe)
);

// File: tb/test_failsafe_out.sv
`timescale 1ns/1ps
module test_failsafe_out;

    localparam int NS  = 10;
    localparam int NC  = 2;
    localparam int WW  = 20;
    localparam int LIM = 35;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NC*NS-1:0] tb_word = '0;
    logic          tb_dv = 1'b0;
    logic          tb_err = 1'b0;
    logic          tb_we = 1'b0;
    logic [15:0]   tb_wdata = '0;
    logic [WW-1:0] tb_lim = WW'(LIM);
    logic [NC-1:0] lvl, oe;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    // reference model state
    int          m_idx, m_wd;
    bit          m_pv, m_pe, m_miss, m_alt, m_ret, m_cfgnew, m_inrst;
    logic [NS-1:0] m_blk [NC];
    logic [NS-1:0] m_inb [NC];
    logic [7:0]  m_cfg [NC];

    failsafe_out #(.NSAMP(NS), .NCH(NC), .WD_W(WW)) i_failsafe_out (
        .clk(clk), .rst(rst), .data_word(tb_word), .data_valid(tb_dv),
        .cycle_err(tb_err), .cfg_we(tb_we), .cfg_wdata(tb_wdata),
        .wd_limit(tb_lim), .out_lvl(lvl), .out_oe(oe)
    );

    always #2.5 clk = ~clk;

    function automatic int ph_of(int wd, bit miss);
        if (wd >= LIM) return 2;
        return miss ? 1 : 0;
    endfunction

    // returns 0 zero,1 one,2 hold,3 stale buffer,4 block,5 alt,6 off
    function automatic int exp_act(int ph, logic [7:0] cb);
        int code;
        if (ph == 0) return 4;
        if (!cb[0]) return (ph == 1) ? 4 : 0;
        code = (ph == 1) ? int'(cb[3:1]) : int'(cb[6:4]);
        case (code)
            0: return 0;
            1: return 1;
            2: return 2;
            3: return (ph == 1) ? 3 : 4;
            4: return 5;
            5: return 6;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_idx = 0; m_wd = 0; m_pv = 0; m_pe = 0; m_miss = 0; m_alt = 0;
            m_ret = 0; m_cfgnew = 0; m_inrst = 1;
            for (int c = 0; c < NC; c++) begin
                m_blk[c] = '0; m_inb[c] = '0; m_cfg[c] = '0;
            end
        end else begin
            bit last, ev, ee, ld;
            int pc, pn;
            m_inrst = 0;
            last = (m_idx == NS - 1);
            ev = m_pv || tb_dv;
            ee = tb_dv ? tb_err : m_pe;
            ld = last && ev && !ee;
            pc = ph_of(m_wd, m_miss);
            for (int c = 0; c < NC; c++) begin
                if (ld) m_blk[c] = tb_dv ? tb_word[c*NS +: NS] : m_inb[c];
                if (tb_dv) m_inb[c] = tb_word[c*NS +: NS];
                if (tb_we) m_cfg[c] = tb_wdata[c*8 +: 8];
            end
            m_cfgnew = tb_we;
            if (ld) m_wd = 0;
            else if (m_wd < LIM) m_wd++;
            if (last) m_miss = !ld;
            m_pv = last ? 0 : ev;
            m_pe = last ? 0 : ee;
            m_idx = last ? 0 : m_idx + 1;
            pn = ph_of(m_wd, m_miss);
            m_alt = (pn != pc) ? 0 : !m_alt;
            m_ret = ld && (pc != 0);
        end
    end

    task automatic check_now();
        for (int c = 0; c < NC; c++) begin
            int ph, a;
            logic el, eo;
            string tag;
            ph = ph_of(m_wd, m_miss);
            a = exp_act(ph, m_cfg[c]);
            eo = 1'b1;
            case (a)
                0: el = 1'b0;
                1: el = 1'b1;
                2: el = m_blk[c][NS-1];
                3: el = m_inb[c][m_idx];
                4: el = m_blk[c][m_idx];
                5: el = m_alt;
                default: begin el = 1'b0; eo = 1'b0; end
            endcase
            if (m_inrst) tag = "R1";
            else if (ph == 0) tag = m_ret ? "R10" : "R2";
            else if (ph == 1) tag = m_cfg[c][0] ? "R4" : "R3";
            else tag = "R5 R6";
            if (a == 5) tag = {tag, " R7"};
            if (a == 6) tag = {tag, " R8"};
            if (m_cfgnew) tag = {tag, " R9"};
            n_cmp++;
            if (lvl[c] !== el || oe[c] !== eo) begin
                n_bad++;
                $display("FAIL %s ch%0d: lvl=%0b oe=%0b expected lvl=%0b oe=%0b (cycle %0d)",
                         tag, c, lvl[c], oe[c], el, eo, cyc);
            end
        end
    endtask

    task automatic step(bit dv, bit err, logic [NC*NS-1:0] w, bit we, logic [15:0] wd);
        @(negedge clk);
        check_now();
        tb_dv = dv; tb_err = err; tb_word = w; tb_we = we; tb_wdata = wd;
    endtask

    // kind: 0 good, 1 flagged, 2 silent
    task automatic run_block(int kind, bit we, logic [15:0] wd);
        int pos;
        logic [NC*NS-1:0] w;
        pos = int'($urandom % NS);
        w = (NC*NS)'({$urandom, $urandom});
        for (int s = 0; s < NS; s++)
            step(kind != 2 && s == pos, kind == 1, w, we && s == 0, wd);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        void'($urandom(32'd7177));
        // R1: reset state checked while reset is held
        repeat (3) step(0, 0, '0, 0, '0);
        rst = 1'b0;
        // R2: steady good cycles, default config
        repeat (6) run_block(0, 0, '0);
        // R3 then R5/R6: silence with default config
        repeat (5) run_block(2, 0, '0);
        // R10: recovery
        repeat (3) run_block(0, 0, '0);
        // R9: both bytes in one write; ch0 miss=ONE, ch1 miss=OFF, wd ALT/REP
        run_block(0, 1, {8'h3B, 8'h43});
        repeat (2) run_block(1, 0, '0);
        repeat (4) run_block(2, 0, '0);
        run_block(0, 0, '0);
        // ch0 stale buffer in phase 2, hold in phase 3; ch1 hold/alt
        run_block(0, 1, {8'h45, 8'h27});
        repeat (2) run_block(1, 0, '0);
        repeat (4) run_block(2, 0, '0);
        run_block(0, 0, '0);
        // random mix
        for (int b = 0; b < 320; b++) begin
            int r;
            bit we;
            r = int'($urandom % 8);
            we = ($urandom % 6) == 0;
            run_block(r < 4 ? 0 : (r == 4 ? 1 : 2), we, 16'($urandom) & 16'h7F7F);
            if (b % 60 == 59) repeat (5) run_block(2, 0, '0);
        end
        step(0, 0, '0, 0, '0);
        finish_run();
    end

    initial begin
        while (cyc < 100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, cycles=%0d expected < %0d", cyc, 100000);
        finish_run();
    end

endmodule